// File: doc/BRIEF.md
# Memory Window Hit Decoder

This block sits behind the transaction receive path of an endpoint. Every incoming memory read or write presents its 32-bit request address together with a one-cycle valid pulse. The block compares that address with each of six programmable window bases. Each window has a fixed power-of-two size that is set at build time. The block reports every window the address falls in, picks one winner, and passes on the local offset inside the winner's window. An address that reaches the endpoint but lands in no window raises a miss flag, so that later logic can treat it as a fault.

Window sizes, and whether a window exists at all, are parameters. Bases come in as live inputs from the configuration registers. A window of size 2^L matches when the address bits from bit L upward equal the same bits of its base. Base bits below L play no part. A global decode enable keeps every window silent until software has set up the bases. All results are registered and appear one clock after the request, qualified by a one-cycle result strobe.

Top module: `win_hit_decoder`

## Requirements
- R1: A request hits window i when address bits [31:L_i] equal bits [31:L_i] of base i, where 2^L_i is the window size. With the defaults (L0=27, L1=26), a base 0x2000_0000 on window 0 is hit by 0x2000_0000..0x27FF_FFFF, and a base 0x3800_0000 on window 1 is hit by 0x3800_0000..0x3BFF_FFFF.
- R2: On a hit, `offset_o` holds the address bits [L-1:0] of the winning window, and its upper bits are zero. On a miss, `offset_o` is zero.
- R3: A request that hits no window drives `miss_o`=1, `hit_vec_o`=0 and `hit_idx_o`=0. A request that hits gives `miss_o`=0.
- R4: A window whose implemented-mask bit is 0 never hits, even when the address equals its base. In the default build only window 4 is not implemented.
- R5: When several windows hit, `hit_vec_o` has one bit set for each hitting window (bit i is window i). `hit_idx_o` gives the lowest hitting window number in binary, and the offset follows that window.
- R6: Results appear on the clock edge after the one where `req_valid_i` is high, with `res_valid_o` high for exactly that one cycle. Between results, all result outputs keep their last values.
- R7: While `dec_en_i` is 0, no window hits and every request reports a miss.
- R8: After reset, every output is zero.
- R9: Base bits below a window's size have no effect on matching or on the offset.
- R10: `bar_base_i` carries base i in bits [32*i+31:32*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_en_i | input | 1 | Global memory decode enable |
| bar_base_i | input | 192 | Six window bases; base i is in bits [32*i+31:32*i] |
| req_valid_i | input | 1 | Request address is valid this cycle |
| req_addr_i | input | 32 | Request address |
| res_valid_o | output | 1 | One-cycle strobe marking a new result |
| hit_vec_o | output | 6 | One bit per window that the last request hit |
| hit_idx_o | output | 3 | Number of the winning window |
| offset_o | output | 32 | Local offset inside the winning window |
| miss_o | output | 1 | Last request hit no window |

## Verification
A comparator with a wrong mask width shows up on the very next result. It either widens or narrows the accepted range, which is visible at a window edge address, or it leaks base bits into the offset. A slip in the priority chain appears only when windows overlap, so overlapping bases are set up on purpose. A result register that fails to hold or that strobes twice shows up as an unexpected or changed output on the cycle after an idle one. Each of these faults surfaces one clock after the offending request.

// File: rtl/win_dec_pkg.sv
package win_dec_pkg;

    localparam int unsigned DEF_SLOTS  = 6;
    localparam int unsigned DEF_ABITS  = 32;

    // Low-bit mask of a window of size 2**l, saturating at 64 bits.
    function automatic logic [63:0] low_ones(input int unsigned l);
        logic [63:0] m;
        if (l >= 64) m = '1;
        else         m = (64'd1 << l) - 64'd1;
        return m;
    endfunction

endpackage

// File: rtl/win_cmp.sv
module win_cmp
    import win_dec_pkg::*;
#(
    parameter int unsigned ABITS   = DEF_ABITS,
    parameter int unsigned LOG2SZ  = 12,
    parameter bit          PRESENT = 1'b1
) (
    input  logic             en_i,
    input  logic [ABITS-1:0] base_i,
    input  logic [ABITS-1:0] addr_i,
    output logic             hit_o
);

    localparam logic [63:0]      LOW_W   = low_ones(LOG2SZ);
    localparam logic [ABITS-1:0] UPPER_M = ~LOW_W[ABITS-1:0];

    generate
        if (PRESENT) begin : g_live
            assign hit_o = en_i && (((addr_i ^ base_i) & UPPER_M) == '0);
        end else begin : g_absent
            logic unused_w;
            assign unused_w = en_i ^ (^base_i) ^ (^addr_i);
            assign hit_o    = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/win_sel.sv
module win_sel
    import win_dec_pkg::*;
#(
    parameter int unsigned SLOTS = DEF_SLOTS,
    parameter int unsigned ABITS = DEF_ABITS,
    parameter int unsigned IDXW  = 3,
    parameter int unsigned LOG2SZ [SLOTS] = '{27, 26, 11, 20, 12, 16}
) (
    input  logic [SLOTS-1:0] hits_i,
    input  logic [ABITS-1:0] addr_i,
    output logic [IDXW-1:0]  idx_o,
    output logic [ABITS-1:0] offset_o,
    output logic             any_o
);

    always_comb begin
        logic [63:0] m_d;
        idx_o    = '0;
        offset_o = '0;
        any_o    = |hits_i;
        m_d      = '0;
        // Walk from the top down so the lowest hitting window is written last.
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (hits_i[i]) begin
                idx_o = IDXW'(i);
                m_d   = low_ones(LOG2SZ[i]);
            end
        end
        offset_o = addr_i & m_d[ABITS-1:0];
    end

endmodule

// File: rtl/win_hit_decoder.sv
module win_hit_decoder
    import win_dec_pkg::*;
#(
    parameter int unsigned    SLOTS = DEF_SLOTS,
    parameter int unsigned    ABITS = DEF_ABITS,
    parameter int unsigned    LOG2SZ [SLOTS] = '{27, 26, 11, 20, 12, 16},
    parameter logic [SLOTS-1:0] PRESENT = 6'b101111,
    localparam int unsigned   IDXW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dec_en_i,
    input  logic [SLOTS*ABITS-1:0] bar_base_i,
    input  logic                   req_valid_i,
    input  logic [ABITS-1:0]       req_addr_i,
    output logic                   res_valid_o,
    output logic [SLOTS-1:0]       hit_vec_o,
    output logic [IDXW-1:0]        hit_idx_o,
    output logic [ABITS-1:0]       offset_o,
    output logic                   miss_o
);

    typedef struct packed {
        logic             valid;
        logic [SLOTS-1:0] hits;
        logic [IDXW-1:0]  idx;
        logic [ABITS-1:0] offset;
        logic             miss;
    } res_t;

    res_t             res_d, res_q;
    logic [SLOTS-1:0] hits_w;
    logic [IDXW-1:0]  idx_w;
    logic [ABITS-1:0] off_w;
    logic             any_w;

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_win
            win_cmp #(
                .ABITS  (ABITS),
                .LOG2SZ (LOG2SZ[g]),
                .PRESENT(PRESENT[g])
            ) i_cmp (
                .en_i  (dec_en_i),
                .base_i(bar_base_i[g*ABITS +: ABITS]),
                .addr_i(req_addr_i),
                .hit_o (hits_w[g])
            );
        end
    endgenerate

    win_sel #(
        .SLOTS (SLOTS),
        .ABITS (ABITS),
        .IDXW  (IDXW),
        .LOG2SZ(LOG2SZ)
    ) i_sel (
        .hits_i  (hits_w),
        .addr_i  (req_addr_i),
        .idx_o   (idx_w),
        .offset_o(off_w),
        .any_o   (any_w)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = req_valid_i;
        if (req_valid_i) begin
            res_d.hits   = hits_w;
            res_d.idx    = idx_w;
            res_d.offset = off_w;
            res_d.miss   = ~any_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_valid_o = res_q.valid;
    assign hit_vec_o   = res_q.hits;
    assign hit_idx_o   = res_q.idx;
    assign offset_o    = res_q.offset;
    assign miss_o      = res_q.miss;

    // R6: strobe follows the request by exactly one clock.
    assert_strobe_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> res_valid_o);
    assert_no_spurious_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!res_valid_o && $stable(hit_vec_o) && $stable(offset_o) && $stable(miss_o)));
    // R3: a miss carries no hit bits and no offset.
    assert_miss_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        miss_o |-> (hit_vec_o == '0 && offset_o == '0 && hit_idx_o == '0));
    // R5: winner is a hitting window and none below it hit.
    assert_winner_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !miss_o) |->
            (hit_vec_o[hit_idx_o] && ((hit_vec_o & ((SLOTS'(1) << hit_idx_o) - SLOTS'(1))) == '0)));
    // R4: absent windows never show up.
    assert_absent_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec_o & ~PRESENT) == '0);
    // R7: decode disabled means every request misses.
    assert_disabled_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !dec_en_i) |=> miss_o);

endmodule

// File: tb/test_win_hit_decoder.sv
module test_win_hit_decoder;

    localparam int unsigned NB = 6;
    localparam int unsigned LG [NB] = '{27, 26, 11, 20, 12, 16};
    localparam logic [NB-1:0] PRES = 6'b101111;

    typedef struct {
        logic [NB-1:0] hits;
        logic [2:0]    idx;
        logic [31:0]   off;
        logic          miss;
        string         tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           dec_en = 1'b0;
    logic [NB*32-1:0] bases = '0;
    logic           req_valid = 1'b0;
    logic [31:0]    req_addr = '0;
    logic           res_valid;
    logic [NB-1:0]  hit_vec;
    logic [2:0]     hit_idx;
    logic [31:0]    offset;
    logic           miss;

    int checks = 0;
    int fails  = 0;
    exp_t sb[$];

    always #10 clk = ~clk;

    win_hit_decoder i_win_hit_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_en_i   (dec_en),
        .bar_base_i (bases),
        .req_valid_i(req_valid),
        .req_addr_i (req_addr),
        .res_valid_o(res_valid),
        .hit_vec_o  (hit_vec),
        .hit_idx_o  (hit_idx),
        .offset_o   (offset),
        .miss_o     (miss)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Range-based reference model.
    function automatic exp_t model(input logic [31:0] a, input string tag);
        exp_t e;
        logic [63:0] sz, ab;
        e.hits = '0; e.idx = '0; e.off = '0; e.miss = 1'b1; e.tag = tag;
        for (int i = NB - 1; i >= 0; i--) begin
            sz = 64'd1 << LG[i];
            ab = {32'd0, bases[i*32 +: 32]} / sz * sz;
            if (dec_en && PRES[i] && {32'd0, a} >= ab && {32'd0, a} < ab + sz) begin
                e.hits[i] = 1'b1;
                e.idx     = 3'(i);
                e.off     = 32'({32'd0, a} - ab);
                e.miss    = 1'b0;
            end
        end
        return e;
    endfunction

    task automatic set_base(input int i, input logic [31:0] b);
        bases[i*32 +: 32] = b;
    endtask

    // Driver: one request per call, issued at the falling edge.
    task automatic send(input logic [31:0] a, input string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        sb.push_back(model(a, tag));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Monitor: compares each result strobe against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R6", "strobe without request", 64'(res_valid), 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(hit_vec == e.hits, e.tag, "hit_vec", 64'(hit_vec), 64'(e.hits));
                check(hit_idx == e.idx,  e.tag, "hit_idx", 64'(hit_idx), 64'(e.idx));
                check(offset  == e.off,  e.tag, "offset",  64'(offset),  64'(e.off));
                check(miss    == e.miss, e.tag, "miss",    64'(miss),    64'(e.miss));
            end
        end
    end

    initial begin
        #2_000_000;
        check(1'b0, "WDOG", "watchdog expired", 64'd0, 64'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] held_off;
        repeat (3) @(negedge clk);
        // R8: reset state
        check({res_valid, hit_vec, hit_idx, offset, miss} == '0, "R8", "reset outputs",
              64'({res_valid, hit_vec, hit_idx, offset, miss}), 64'd0);
        rst_n = 1'b1;
        // R10: base i placed in its 32-bit lane
        set_base(0, 32'h2000_0000);
        set_base(1, 32'h3800_0000);
        set_base(2, 32'h4000_0800);
        set_base(3, 32'h5000_0000);
        set_base(4, 32'h6000_0000);
        set_base(5, 32'h7000_0000);

        // R7: decode disabled
        send(32'h2000_0000, "R7");
        send(32'h0000_0000, "R7");
        idle(2);
        dec_en = 1'b1;

        // R1 / R2 window edges
        send(32'h2000_0000, "R1");
        send(32'h27FF_FFFF, "R1");
        send(32'h2800_0000, "R3");
        send(32'h1FFF_FFFF, "R3");
        send(32'h3800_0000, "R1");
        send(32'h3BFF_FFFF, "R2");
        send(32'h3C00_0000, "R3");
        send(32'h4000_0FFF, "R2");
        send(32'h4000_0800, "R2");
        send(32'h4000_1000, "R3");
        send(32'h7000_1234, "R2");
        send(32'h6000_0000, "R4");
        send(32'h6000_0004, "R4");
        idle(2);

        // R6: outputs hold across idle cycles
        send(32'h5000_0ABC, "R6");
        idle(1);
        held_off = offset;
        idle(3);
        check(offset == held_off && offset == 32'h0000_0ABC && !res_valid, "R6",
              "hold after idle", 64'(offset), 64'h0ABC);

        // R9: junk in base bits below the window size
        set_base(1, 32'h3800_1234);
        set_base(2, 32'h4000_0BFF);
        send(32'h3800_0010, "R9");
        send(32'h4000_0801, "R9");
        idle(2);

        // R5: overlapping windows, window 3 inside window 0
        set_base(3, 32'h2010_0000);
        send(32'h2010_0040, "R5");
        send(32'h201F_FFFF, "R5");
        send(32'h2020_0000, "R5");
        idle(2);
        check(hit_vec == 6'b000001 && hit_idx == 3'd0, "R5", "after overlap",
              64'(hit_vec), 64'h1);

        // Sweep addresses around every window
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a;
            int w;
            w = n % NB;
            a = bases[w*32 +: 32] + 32'($urandom_range(0, 32'h0900_0000)) - 32'h0080_0000;
            send(a, "R1");
            if (n % 7 == 0) idle(1);
        end
        idle(3);
        check(sb.size() == 0, "R6", "pending results", 64'(sb.size()), 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule